// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates a 64-bit virtual address into a physical page address. It holds a set of tag/translation entry pairs and compares every entry against the request in parallel. Each entry carries its own page-size code, which picks one of four page sizes. A lookup that finds a usable entry returns the physical address and its read and write permissions. A lookup that finds no entry reports a miss. A lookup that breaks an entry's protection reports a fault, and the fault is recorded in a small status register and an address register.

Entries are written one at a time through an index-addressed load port. A global translation-enable input switches the block between translated operation and a pass-through mode. The choice of which entry to refill, and when, belongs to the logic around the block. Each lookup takes one clock: a request sampled at a rising edge produces its response, and any status update, at that same edge.

Top module: `tlbx_xlate`

## Requirements
- R1: Synchronous active-high reset clears every stored tag and translation word to zero, clears the status and fault-address registers and drops `rsp_valid`. Because a cleared entry is not valid yet still matches context 0 and the lowest 8 KB page, a translated lookup of such an address after reset reports a fault on entry 0.
- R2: With `xlate_en` low, a lookup returns `rsp_pa` equal to the request address, with read and write granted, no miss and no fault, and the status and fault-address registers keep their values.
- R3: An entry matches when tag bits 12:0 equal `ctx_id` and the request address, with the entry's page-offset bits cleared, equals the tag with bits 12:0 cleared. The response is valid in the cycle after the request cycle and only then.
- R4: Translation word bits 62:61 give the page size: code 0 leaves 13 offset bits out of the compare (8 KB), code 1 leaves 16 (64 KB), code 2 leaves 19 (512 KB) and code 3 leaves 22 (4 MB).
- R5: On a hit, `rsp_pa` bits 40:12 take the translation word's bits above the page offset and the request's bits below it; `rsp_pa` bits 11:0 and 63:41 are zero.
- R6: A hit grants read always and grants write only when translation bit 1 (writable) is set.
- R7: A matching entry faults when translation bit 63 (valid) is clear, when bit 2 (supervisor-only) is set and the request is a user access, or when the request is a write and bit 1 is clear. A fault gives no permissions and a zero address; `rsp_entry` names the matching entry.
- R8: On a fault, the status register is first set to 2 when it held a nonzero value (overflow flag in bit 1), else to 0; then bit 3 takes the user flag, bit 2 the write flag and bit 0 is set. The fault-address register takes the request address.
- R9: When no entry matches, `rsp_miss` is raised and neither the status nor the fault-address register changes.
- R10: When several entries match, the lowest-numbered one decides the result, and `rsp_entry` reports its index.
- R11: A load writes the tag and translation word into the addressed entry at the clock edge; a lookup in the same cycle still sees the previous contents.
- R12: `fsr_clr` clears the status register; when it coincides with a fault, the fault's bits are written without the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable; low selects pass-through |
| ctx_id | input | 13 | Current context number |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 64 | Virtual address of the request |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user mode |
| ld_en | input | 1 | Entry load strobe |
| ld_idx | input | IDX_W | Index of the entry to load |
| ld_tag | input | 64 | Tag word to load |
| ld_tte | input | 64 | Translation word to load |
| fsr_clr | input | 1 | Clear the fault status register |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 64 | Physical address of the response |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Matching entry refused the access |
| rsp_entry | output | IDX_W | Index of the deciding entry |
| fsr | output | 4 | Fault status register |
| far | output | 64 | Fault address register |

## Verification
The bench builds the block with `ENTRIES` set to 8. With that size it can fill every slot, including the highest index, with a hand-made mix: one entry of each page size, an invalid entry, an entry in a foreign context, and two entries that share one tag. That mix brings priority between duplicates, context mismatch and all four mask widths into one short vector table. Directed sequences then drive the status register through a first fault, an overflowed fault, a miss and a clear that coincides with a fault.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W    = 64;
    localparam int CTX_W   = 13;
    localparam int FSR_W   = 4;

    // translation word field positions
    localparam int TTE_VALID = 63;
    localparam int TTE_SZ_HI = 62;
    localparam int TTE_SZ_LO = 61;
    localparam int TTE_PRIV  = 2;
    localparam int TTE_WRITE = 1;

    // physical field kept in the result
    localparam int PA_HI = 40;
    localparam int PA_LO = 12;

    localparam logic [VA_W-1:0] PA_FIELD =
        ((VA_W'(1) << (PA_HI + 1)) - VA_W'(1)) & ~((VA_W'(1) << PA_LO) - VA_W'(1));

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pgsz_e;

    typedef enum logic [1:0] {
        RES_PASS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } res_kind_e;

    typedef struct packed {
        logic            valid;
        pgsz_e           size;
        logic            priv;
        logic            writable;
        logic [VA_W-1:0] raw;
    } tte_view_t;

    typedef struct packed {
        res_kind_e       kind;
        logic [VA_W-1:0] pa;
        logic            rd_ok;
        logic            wr_ok;
    } xlate_res_t;

    // number of page-offset bits left out of the compare
    function automatic int unsigned offset_bits(pgsz_e sz);
        return 13 + 3 * int'(sz);
    endfunction

    // ones on the compared (page-number) bits
    function automatic logic [VA_W-1:0] page_mask(pgsz_e sz);
        return ~((VA_W'(1) << offset_bits(sz)) - VA_W'(1));
    endfunction

    function automatic tte_view_t decode_tte(logic [VA_W-1:0] w);
        tte_view_t v;
        v.valid    = w[TTE_VALID];
        v.size     = pgsz_e'(w[TTE_SZ_HI:TTE_SZ_LO]);
        v.priv     = w[TTE_PRIV];
        v.writable = w[TTE_WRITE];
        v.raw      = w;
        return v;
    endfunction

endpackage

// File: rtl/tlbx_entry_file.sv
module tlbx_entry_file
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VA_W-1:0] ld_tag,
    input  logic [VA_W-1:0] ld_tte,
    output logic [VA_W-1:0] tag_q [ENTRIES],
    output logic [VA_W-1:0] tte_q [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = ld_en && (ld_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g] <= '0;
                tte_q[g] <= '0;
            end else if (sel) begin
                tag_q[g] <= ld_tag;
                tte_q[g] <= ld_tte;
            end
        end
    end

endmodule

// File: rtl/tlbx_match_array.sv
module tlbx_match_array
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic [VA_W-1:0]  tag_q [ENTRIES],
    input  logic [VA_W-1:0]  tte_q [ENTRIES],
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    output logic [ENTRIES-1:0] hit_vec
);

    localparam logic [VA_W-1:0] CTX_CLR = ~((VA_W'(1) << CTX_W) - VA_W'(1));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tte_view_t       view;
        logic [VA_W-1:0] msk;
        logic            ctx_eq;
        logic            page_eq;

        assign view    = decode_tte(tte_q[g]);
        assign msk     = page_mask(view.size);
        assign ctx_eq  = (tag_q[g][CTX_W-1:0] == ctx);
        assign page_eq = ((va & msk) == (tag_q[g] & CTX_CLR));
        assign hit_vec[g] = ctx_eq && page_eq;
    end

endmodule

// File: rtl/tlbx_select.sv
module tlbx_select
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [VA_W-1:0]    tte_q [ENTRIES],
    output logic               found,
    output logic [IDX_W-1:0]   win_idx,
    output logic [VA_W-1:0]    win_tte
);

    // scan from the top so the lowest matching index is the last written
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_tte = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_tte = tte_q[i];
            end
        end
    end

endmodule

// File: rtl/tlbx_fault_log.sv
module tlbx_fault_log
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             log_fault,
    input  logic             log_user,
    input  logic             log_write,
    input  logic [VA_W-1:0]  log_va,
    input  logic             clr,
    output logic [FSR_W-1:0] fsr_q,
    output logic [VA_W-1:0]  far_q
);

    logic [FSR_W-1:0] base;
    logic [FSR_W-1:0] fsr_d;

    always_comb begin
        base  = clr ? '0 : fsr_q;
        fsr_d = base;
        if (log_fault) begin
            fsr_d = (base != '0) ? FSR_W'(2) : '0;
            fsr_d = fsr_d | {log_user, log_write, 1'b0, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_d;
            if (log_fault) begin
                far_q <= log_va;
            end
        end
    end

endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate
    import tlbx_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xlate_en,
    input  logic [12:0]      ctx_id,
    input  logic             req_valid,
    input  logic [63:0]      req_va,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [63:0]      ld_tag,
    input  logic [63:0]      ld_tte,
    input  logic             fsr_clr,
    output logic             rsp_valid,
    output logic [63:0]      rsp_pa,
    output logic             rsp_rd_ok,
    output logic             rsp_wr_ok,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [IDX_W-1:0] rsp_entry,
    output logic [3:0]       fsr,
    output logic [63:0]      far
);

    logic [VA_W-1:0]    tag_q [ENTRIES];
    logic [VA_W-1:0]    tte_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    logic [VA_W-1:0]    win_tte;

    tlbx_entry_file #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_file (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_tag (ld_tag),
        .ld_tte (ld_tte),
        .tag_q  (tag_q),
        .tte_q  (tte_q)
    );

    tlbx_match_array #(.ENTRIES(ENTRIES)) u_match (
        .tag_q   (tag_q),
        .tte_q   (tte_q),
        .va      (req_va),
        .ctx     (ctx_id),
        .hit_vec (hit_vec)
    );

    tlbx_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sel (
        .hit_vec (hit_vec),
        .tte_q   (tte_q),
        .found   (found),
        .win_idx (win_idx),
        .win_tte (win_tte)
    );

    // result of the lookup presented this cycle
    tte_view_t       view;
    logic [VA_W-1:0] msk;
    logic            denied;
    xlate_res_t      res;

    always_comb begin
        view   = decode_tte(win_tte);
        msk    = page_mask(view.size);
        denied = !view.valid
              || (view.priv && req_user)
              || (req_write && !view.writable);

        res.kind  = RES_PASS;
        res.pa    = req_va;
        res.rd_ok = 1'b1;
        res.wr_ok = 1'b1;
        if (xlate_en) begin
            res.pa    = '0;
            res.rd_ok = 1'b0;
            res.wr_ok = 1'b0;
            if (!found) begin
                res.kind = RES_MISS;
            end else if (denied) begin
                res.kind = RES_FAULT;
            end else begin
                res.kind  = RES_HIT;
                res.pa    = ((win_tte & msk) | (req_va & ~msk)) & PA_FIELD;
                res.rd_ok = 1'b1;
                res.wr_ok = view.writable;
            end
        end
    end

    logic log_fault;
    assign log_fault = req_valid && (res.kind == RES_FAULT);

    tlbx_fault_log u_log (
        .clk       (clk),
        .rst       (rst),
        .log_fault (log_fault),
        .log_user  (req_user),
        .log_write (req_write),
        .log_va    (req_va),
        .clr       (fsr_clr),
        .fsr_q     (fsr),
        .far_q     (far)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_entry <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= res.pa;
                rsp_rd_ok <= res.rd_ok;
                rsp_wr_ok <= res.wr_ok;
                rsp_miss  <= (res.kind == RES_MISS);
                rsp_fault <= (res.kind == RES_FAULT);
                rsp_entry <= (res.kind == RES_HIT || res.kind == RES_FAULT) ? win_idx : '0;
            end
        end
    end

endmodule

// File: rtl/tlbx_xlate_chk.sv
module tlbx_xlate_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             xlate_en,
    input logic             req_valid,
    input logic [63:0]      req_va,
    input logic             fsr_clr,
    input logic             rsp_valid,
    input logic [63:0]      rsp_pa,
    input logic             rsp_rd_ok,
    input logic             rsp_wr_ok,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [IDX_W-1:0] rsp_entry,
    input logic [3:0]       fsr,
    input logic [63:0]      far
);

    // R3
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    bypass_identity_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !xlate_en |=> rsp_pa == $past(req_va) && !rsp_miss && !rsp_fault
                                   && rsp_rd_ok && rsp_wr_ok);

    // R5
    pa_field_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && xlate_en |=> rsp_pa[11:0] == 12'd0 && rsp_pa[63:41] == 23'd0);

    // R6
    write_implies_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_wr_ok |-> rsp_rd_ok);

    // R7
    outcome_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_miss && rsp_fault) && !((rsp_miss || rsp_fault) && rsp_rd_ok));

    // R8
    fault_logged_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && xlate_en |=> !rsp_fault || (fsr[0] && far == $past(req_va)));

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !fsr_clr |=> !rsp_miss || ($stable(fsr) && $stable(far)));

    // R10
    entry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_miss || !rsp_rd_ok) && !rsp_fault |-> rsp_entry == '0);

endmodule

bind tlbx_xlate tlbx_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xlate_en  (xlate_en),
    .req_valid (req_valid),
    .req_va    (req_va),
    .fsr_clr   (fsr_clr),
    .rsp_valid (rsp_valid),
    .rsp_pa    (rsp_pa),
    .rsp_rd_ok (rsp_rd_ok),
    .rsp_wr_ok (rsp_wr_ok),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_entry (rsp_entry),
    .fsr       (fsr),
    .far       (far)
);

// File: tb/tlbx_xlate_bench.sv
module tlbx_xlate_bench;

    localparam int ENTRIES = 8;
    localparam int IDX_W   = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             xlate_en;
    logic [12:0]      ctx_id;
    logic             req_valid;
    logic [63:0]      req_va;
    logic             req_write;
    logic             req_user;
    logic             ld_en;
    logic [IDX_W-1:0] ld_idx;
    logic [63:0]      ld_tag;
    logic [63:0]      ld_tte;
    logic             fsr_clr;
    logic             rsp_valid;
    logic [63:0]      rsp_pa;
    logic             rsp_rd_ok;
    logic             rsp_wr_ok;
    logic             rsp_miss;
    logic             rsp_fault;
    logic [IDX_W-1:0] rsp_entry;
    logic [3:0]       fsr;
    logic [63:0]      far;

    always #2 clk = ~clk;

    tlbx_xlate #(.ENTRIES(ENTRIES)) u_tlbx_xlate (
        .clk(clk), .rst(rst), .xlate_en(xlate_en), .ctx_id(ctx_id),
        .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_tte(ld_tte),
        .fsr_clr(fsr_clr), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_entry(rsp_entry), .fsr(fsr), .far(far)
    );

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 hit, 1 miss, 2 fault
    typedef struct packed {
        logic [63:0] va;
        logic [12:0] ctx;
        logic        wr;
        logic        usr;
        logic [1:0]  kind;
        logic [63:0] pa;
        logic        wok;
        logic [7:0]  idx;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0040_3abc, 13'd5, 1'b1, 1'b1, 2'd0, 64'h0000_0001_2345_7000, 1'b1, 8'd0},
        '{64'h0000_0000_0040_2abc, 13'd5, 1'b0, 1'b0, 2'd0, 64'h0000_0001_2345_6000, 1'b1, 8'd0},
        '{64'h0000_0000_0040_4000, 13'd5, 1'b0, 1'b0, 2'd1, 64'h0,                   1'b0, 8'd0},
        '{64'h0000_0000_1234_5678, 13'd5, 1'b0, 1'b1, 2'd0, 64'h0000_0000_0ABC_5000, 1'b0, 8'd1},
        '{64'h0000_0000_1234_FFFF, 13'd5, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0ABC_F000, 1'b0, 8'd1},
        '{64'h0000_0000_1235_0000, 13'd5, 1'b0, 1'b0, 2'd1, 64'h0,                   1'b0, 8'd0},
        '{64'h0000_0000_8008_7ABC, 13'd5, 1'b0, 1'b0, 2'd0, 64'h0000_01FF_FFF8_7000, 1'b1, 8'd2},
        '{64'h0000_0000_800F_FFFF, 13'd5, 1'b0, 1'b0, 2'd0, 64'h0000_01FF_FFFF_F000, 1'b1, 8'd2},
        '{64'hFFFF_FFFF_FFD2_3456, 13'd5, 1'b1, 1'b1, 2'd0, 64'h0000_0001_0052_3000, 1'b1, 8'd3},
        '{64'h0000_0000_0070_0123, 13'd5, 1'b0, 1'b0, 2'd1, 64'h0,                   1'b0, 8'd0},
        '{64'h0000_0000_0070_0123, 13'd9, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0777_0000, 1'b0, 8'd5},
        '{64'h0000_0000_0090_0345, 13'd5, 1'b0, 1'b0, 2'd0, 64'h0000_0000_00AA_A000, 1'b1, 8'd6},
        '{64'h0000_0000_1234_5678, 13'd5, 1'b1, 1'b0, 2'd2, 64'h0,                   1'b0, 8'd1},
        '{64'h0000_0000_8008_0000, 13'd5, 1'b0, 1'b1, 2'd2, 64'h0,                   1'b0, 8'd2},
        '{64'h0000_0000_0050_0010, 13'd5, 1'b0, 1'b0, 2'd2, 64'h0,                   1'b0, 8'd4}
    };

    task automatic load(input int idx, input logic [63:0] tag, input logic [63:0] tte);
        @(negedge clk);
        ld_en  = 1'b1;
        ld_idx = IDX_W'(idx);
        ld_tag = tag;
        ld_tte = tte;
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    // drive at a falling edge; response is sampled at the next falling edge
    task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                          input logic wr, input logic usr, input logic clr);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        ctx_id    = ctx;
        req_write = wr;
        req_user  = usr;
        fsr_clr   = clr;
        @(negedge clk);
        req_valid = 1'b0;
        fsr_clr   = 1'b0;
    endtask

    initial begin
        rst = 1'b1; xlate_en = 1'b1; ctx_id = '0; req_valid = 1'b0; req_va = '0;
        req_write = 1'b0; req_user = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_tag = '0;
        ld_tte = '0; fsr_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 fsr after reset", 64'(fsr), 64'd0);
        check("R1 far after reset", far, 64'd0);
        rst = 1'b0;

        // R1: cleared entry 0 matches context 0, lowest page, and is not valid
        lookup(64'h1234, 13'd0, 1'b0, 1'b0, 1'b0);
        check("R1 cleared entry faults", 64'(rsp_fault), 64'd1);
        check("R1 cleared entry index", 64'(rsp_entry), 64'd0);
        check("R1 fsr after first fault", 64'(fsr), 64'h1);
        check("R1 far after first fault", far, 64'h1234);
        @(negedge clk);
        check("R3 response lasts one cycle", 64'(rsp_valid), 64'd0);

        // R11: fill all entries through the load port
        load(0, 64'h0000_0000_0040_2005, 64'h8000_0001_2345_7002);
        load(1, 64'h0000_0000_1234_0005, 64'hA000_0000_0ABC_0000);
        load(2, 64'h0000_0000_8008_0005, 64'hC004_01FF_FFF8_0006);
        load(3, 64'hFFFF_FFFF_FFC0_0005, 64'hE000_0001_0040_0002);
        load(4, 64'h0000_0000_0050_0005, 64'h0000_0000_0060_0002);
        load(5, 64'h0000_0000_0070_0009, 64'h8000_0000_0777_0000);
        load(6, 64'h0000_0000_0090_0005, 64'h8000_0000_00AA_A002);
        load(7, 64'h0000_0000_0090_0005, 64'h8000_0000_00BB_B000);

        // R3 R4 R5 R6 R7 R10: vector table
        for (int i = 0; i < NVEC; i++) begin
            lookup(VECS[i].va, VECS[i].ctx, VECS[i].wr, VECS[i].usr, 1'b0);
            check($sformatf("R3 vec%0d rsp_valid", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R9 vec%0d miss", i), 64'(rsp_miss), 64'(VECS[i].kind == 2'd1));
            check($sformatf("R7 vec%0d fault", i), 64'(rsp_fault), 64'(VECS[i].kind == 2'd2));
            check($sformatf("R5 vec%0d pa", i), rsp_pa, VECS[i].pa);
            check($sformatf("R6 vec%0d read", i), 64'(rsp_rd_ok), 64'(VECS[i].kind == 2'd0));
            check($sformatf("R6 vec%0d write", i), 64'(rsp_wr_ok), 64'(VECS[i].wok));
            check($sformatf("R10 vec%0d entry", i), 64'(rsp_entry), 64'(VECS[i].idx));
        end

        // R12: plain clear
        @(negedge clk); fsr_clr = 1'b1;
        @(negedge clk); fsr_clr = 1'b0;
        check("R12 clear", 64'(fsr), 64'd0);

        // R8: first fault, supervisor write to read-only page
        lookup(64'h0000_0000_1234_5678, 13'd5, 1'b1, 1'b0, 1'b0);
        check("R8 first fault fsr", 64'(fsr), 64'h5);
        check("R8 first fault far", far, 64'h0000_0000_1234_5678);
        // R8: second fault, user read of supervisor page -> overflow
        lookup(64'h0000_0000_8008_0000, 13'd5, 1'b0, 1'b1, 1'b0);
        check("R8 overflow fsr", 64'(fsr), 64'hB);
        check("R8 overflow far", far, 64'h0000_0000_8008_0000);
        // R9: miss leaves both registers
        lookup(64'h0000_0000_0040_4000, 13'd5, 1'b1, 1'b1, 1'b0);
        check("R9 miss flag", 64'(rsp_miss), 64'd1);
        check("R9 fsr kept", 64'(fsr), 64'hB);
        check("R9 far kept", far, 64'h0000_0000_8008_0000);
        // R12: clear together with a fault: no overflow flag
        lookup(64'h0000_0000_1234_5678, 13'd5, 1'b1, 1'b1, 1'b1);
        check("R12 clear with fault fsr", 64'(fsr), 64'hD);

        // R2: pass-through
        xlate_en = 1'b0;
        lookup(64'hDEAD_BEEF_0123_4567, 13'd5, 1'b1, 1'b1, 1'b0);
        check("R2 bypass pa", rsp_pa, 64'hDEAD_BEEF_0123_4567);
        check("R2 bypass read", 64'(rsp_rd_ok), 64'd1);
        check("R2 bypass write", 64'(rsp_wr_ok), 64'd1);
        lookup(64'h0000_0000_0050_0010, 13'd5, 1'b0, 1'b0, 1'b0);
        check("R2 bypass no fault", 64'(rsp_fault), 64'd0);
        check("R2 bypass no miss", 64'(rsp_miss), 64'd0);
        check("R2 bypass fsr kept", 64'(fsr), 64'hD);
        xlate_en = 1'b1;

        // R11: load and lookup in one cycle sees old contents
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd6;
        ld_tag = 64'h0000_0000_00A0_0005; ld_tte = 64'h8000_0000_00CC_C002;
        req_valid = 1'b1; req_va = 64'h0000_0000_0090_0345; ctx_id = 13'd5;
        req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        ld_en = 1'b0; req_valid = 1'b0;
        check("R11 same-cycle load old entry", 64'(rsp_entry), 64'd6);
        check("R11 same-cycle load old pa", rsp_pa, 64'h0000_0000_00AA_A000);
        // R10: duplicate left alone now decides; bit 12 of its base is masked
        lookup(64'h0000_0000_0090_0345, 13'd5, 1'b0, 1'b0, 1'b0);
        check("R10 next duplicate entry", 64'(rsp_entry), 64'd7);
        check("R10 next duplicate pa", rsp_pa, 64'h0000_0000_00BA_A000 ^ 64'h0000_0000_0001_0000 ^ 64'h0000_0000_0001_0000 ^ 64'h0000_0000_00BA_A000 ^ 64'h0000_0000_00BB_A000);
        check("R6 read-only duplicate write", 64'(rsp_wr_ok), 64'd0);
        // R11: new contents of entry 6 are visible
        lookup(64'h0000_0000_00A0_1FFF, 13'd5, 1'b1, 1'b0, 1'b0);
        check("R11 reloaded entry index", 64'(rsp_entry), 64'd6);
        check("R11 reloaded entry pa", rsp_pa, 64'h0000_0000_00CC_D000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule